// File: doc/BRIEF.md
# Hardware Monitor Conversion Sequencer

This block runs the measurement loop of a hardware monitor. Once software sets the run bit, it walks a fixed list of channels, temperature channels first and voltage channels after them. For each conversion it sends a one-cycle start pulse and the channel number to an external converter. It then counts conversion-clock ticks until the conversion time for that channel type has elapsed, and takes the converter's sample at that point.

Each channel is sampled 1, 8, 16 or 32 times in a row. The samples are added together and the sum is shifted right to form the average, which goes into that channel's reading register. The new reading is compared with the channel's high and low limits. A violation sets a sticky status bit, and any status bit that is not masked drives a single interrupt line.

There are two run modes. In free-running mode a new pass starts right after the previous one ends. In paced mode the block waits a programmable number of ticks between passes. A self-clearing soft reset returns every register to its default, except the reading registers, which keep their contents.

Top module: `hwmon_seq`

## Requirements
- R1: After reset the registers read: control (address 0x00) 0x00, mode (0x01) 0x00, idle interval (0x02) 4, status (0x03) 0x00, mask (0x04) 0x00, every high limit (0x10+channel) 0xFF, every low limit (0x18+channel) 0x00. The irq output is low.
- R2: No conversion is started while run bit 0 of the control register is 0, including after reset and after software clears the bit. `convStart` is a single-cycle pulse.
- R3: Channels 0 and 1 are temperature channels of 96 ticks each. Channels 2, 3 and 4 are voltage channels of 68 ticks each. Each pass visits the channels in ascending order starting at 0. With `convTick` held high, a start pulse follows the previous one on the same pass by exactly the previous conversion's length plus one clock.
- R4: Mode register bits [7:5] select the number of samples per channel. Bit 7 set gives 32. Otherwise bit 6 set gives 16. Otherwise bit 5 set gives 8. Otherwise 1. After that many starts the sequence moves to the next channel.
- R5: Reading register 0x08+channel holds the sum of that channel's samples shifted right by log2 of the sample count.
- R6: With mode bit 0 clear, the start pulse for channel 0 follows the last start pulse on channel 4 by 69 clocks.
- R7: With mode bit 0 set and convTick held high, the start pulse for channel 0 follows the last start pulse on channel 4 by 69 + idle + 1 clocks, where idle is the value of register 0x02.
- R8: A new reading sets status bit [channel] only if it is strictly above that channel's high limit or strictly below its low limit. Equality does not set it.
- R9: Status bits stay set until software writes a 1 to them at address 0x03. Writing 0 to a bit leaves it unchanged.
- R10: `irq` is high exactly when some status bit is set whose mask bit (register 0x04, 1 = masked) is clear.
- R11: Writing the control register with bit 7 set restores every non-reading register to its R1 value, even if bit 0 is written as 1 in the same write. Bit 7 reads back as 0. No further conversions start, irq drops, and the reading registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| convTick | input | 1 | One-cycle enable marking each conversion-clock tick |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 5 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 5 | Register read address |
| regRdData | output | 8 | Read data, combinational from regRdAddr |
| convStart | output | 1 | Start pulse to the converter |
| convChan | output | 3 | Channel being converted |
| sampleData | input | 8 | Converter result, taken on the last tick of a conversion |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The spacing assertion relies on only one assumption about the inputs: clearing the run bit ends a spacing window. It therefore holds for any tick pattern, because stopping or soft-resetting the block disarms it. The assertion that a falling irq needs a preceding write expects no reset other than `rstN` and the soft-reset write. The stimulus changes mode, idle interval and limits only while the run bit is clear, and it holds `convTick` high throughout. That way the exact clock spacings in the requirements apply to every measured gap. The converter model keeps `sampleData` steady from each start pulse until the next one.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
  localparam int TEMP_CH   = 2;
  localparam int VOLT_CH   = 3;
  localparam int NUM_CH    = TEMP_CH + VOLT_CH;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = 3;
  localparam int MAX_SHIFT = 5;
  localparam int ACC_W     = DATA_W + MAX_SHIFT;
  localparam int IDLE_W    = 8;
  localparam logic [IDLE_W-1:0] IDLE_DEF = 8'd4;

  // register banks picked by address bits [4:3]
  localparam logic [1:0] BANK_CFG  = 2'd0;
  localparam logic [1:0] BANK_READ = 2'd1;
  localparam logic [1:0] BANK_HIGH = 2'd2;
  localparam logic [1:0] BANK_LOW  = 2'd3;
  // offsets inside the configuration bank
  localparam logic [IDX_W-1:0] CFG_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] CFG_MODE = 3'd1;
  localparam logic [IDX_W-1:0] CFG_IDLE = 3'd2;
  localparam logic [IDX_W-1:0] CFG_STAT = 3'd3;
  localparam logic [IDX_W-1:0] CFG_MASK = 3'd4;

  typedef logic [CH_W-1:0] chan_t;

  typedef struct packed {
    logic  take;    // sample is valid this cycle
    logic  first;   // first sample of the channel
    logic  commit;  // last sample: write the reading
    chan_t chan;
  } strobe_t;

  // priority decode of the averaging field, highest bit wins
  function automatic logic [2:0] avgShift(input logic [2:0] sel);
    if (sel[2])      return 3'd5;
    else if (sel[1]) return 3'd4;
    else if (sel[0]) return 3'd3;
    else             return 3'd0;
  endfunction
endpackage

// File: rtl/hwmon_ctrl.sv
module hwmon_ctrl
  import hwmon_pkg::*;
#(
  parameter int TEMP_CLKS = 96,
  parameter int VOLT_CLKS = 68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convTick,
  input  logic              runEn,
  input  logic              cycleMode,
  input  logic [2:0]        avgSel,
  input  logic [IDLE_W-1:0] idleLen,
  output logic              convStart,
  output chan_t             convChan,
  output strobe_t           strobe
);
  localparam int LEN_MAX = (TEMP_CLKS > VOLT_CLKS) ? TEMP_CLKS : VOLT_CLKS;
  localparam int TICK_W  = $clog2(LEN_MAX);
  localparam int SAMP_W  = MAX_SHIFT + 1;

  typedef enum logic [1:0] {S_OFF, S_ISSUE, S_CONV, S_WAIT} state_t;

  state_t              state;
  chan_t               chanR;
  logic [TICK_W-1:0]   tickCnt;
  logic [SAMP_W-1:0]   sampCnt;
  logic [IDLE_W-1:0]   idleCnt;
  logic [TICK_W-1:0]   lastIdx;
  logic                lastTick;
  logic                sampLast;

  always_comb begin
    lastIdx  = (chanR < CH_W'(TEMP_CH)) ? TICK_W'(TEMP_CLKS - 1) : TICK_W'(VOLT_CLKS - 1);
    lastTick = (tickCnt == lastIdx);
    sampLast = (sampCnt == SAMP_W'((1 << avgShift(avgSel)) - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_OFF;
      chanR   <= '0;
      tickCnt <= '0;
      sampCnt <= '0;
      idleCnt <= '0;
    end else if (!runEn) begin
      state   <= S_OFF;
      chanR   <= '0;
      sampCnt <= '0;
    end else begin
      case (state)
        S_OFF:   state <= S_ISSUE;
        S_ISSUE: begin
          tickCnt <= '0;
          state   <= S_CONV;
        end
        S_CONV: if (convTick) begin
          if (!lastTick) begin
            tickCnt <= tickCnt + TICK_W'(1);
          end else if (!sampLast) begin
            sampCnt <= sampCnt + SAMP_W'(1);
            state   <= S_ISSUE;
          end else begin
            sampCnt <= '0;
            if (chanR == CH_W'(NUM_CH - 1)) begin
              chanR   <= '0;
              idleCnt <= '0;
              state   <= cycleMode ? S_WAIT : S_ISSUE;
            end else begin
              chanR <= chanR + CH_W'(1);
              state <= S_ISSUE;
            end
          end
        end
        S_WAIT: if (convTick) begin
          if (idleCnt == idleLen) state <= S_ISSUE;
          else idleCnt <= idleCnt + IDLE_W'(1);
        end
        default: state <= S_OFF;
      endcase
    end
  end

  always_comb begin
    convStart     = (state == S_ISSUE) && runEn;
    convChan      = chanR;
    strobe.take   = (state == S_CONV) && convTick && lastTick;
    strobe.first  = (sampCnt == '0);
    strobe.commit = strobe.take && sampLast;
    strobe.chan   = chanR;
  end
endmodule

// File: rtl/hwmon_dp.sv
module hwmon_dp
  import hwmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] sampleData,
  input  strobe_t           strobe,
  output logic              runEn,
  output logic              cycleMode,
  output logic [2:0]        avgSel,
  output logic [IDLE_W-1:0] idleLen,
  output logic              irq
);
  logic [NUM_CH-1:0] statR, statNext, maskR;
  logic [DATA_W-1:0] hiLim   [NUM_CH];
  logic [DATA_W-1:0] loLim   [NUM_CH];
  logic [DATA_W-1:0] readingR[NUM_CH];
  logic [ACC_W-1:0]  accR, accBase, sumNext;
  logic [DATA_W-1:0] avgVal;
  logic              hit;

  logic [1:0]       wrBank, rdBank;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic             wrCfg, softRst;

  assign wrBank  = regWrAddr[ADDR_W-1:IDX_W];
  assign wrIdx   = regWrAddr[IDX_W-1:0];
  assign rdBank  = regRdAddr[ADDR_W-1:IDX_W];
  assign rdIdx   = regRdAddr[IDX_W-1:0];
  assign wrCfg   = regWrEn && (wrBank == BANK_CFG);
  assign softRst = wrCfg && (wrIdx == CFG_CTRL) && regWrData[7];

  // averaging datapath
  always_comb begin
    accBase = strobe.first ? '0 : accR;
    sumNext = accBase + ACC_W'(sampleData);
    avgVal  = DATA_W'(sumNext >> avgShift(avgSel));
    hit     = strobe.commit &&
              ((avgVal > hiLim[strobe.chan]) || (avgVal < loLim[strobe.chan]));
  end

  always_comb begin
    statNext = statR;
    if (wrCfg && (wrIdx == CFG_STAT)) statNext = statNext & ~regWrData[NUM_CH-1:0];
    if (hit) statNext[strobe.chan] = 1'b1;
  end

  // configuration, limits and status: power-on and soft reset defaults
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      runEn     <= 1'b0;
      cycleMode <= 1'b0;
      avgSel    <= '0;
      idleLen   <= IDLE_DEF;
      statR     <= '0;
      maskR     <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        hiLim[i] <= '1;
        loLim[i] <= '0;
      end
    end else begin
      statR <= statNext;
      if (wrCfg) begin
        case (wrIdx)
          CFG_CTRL: runEn <= regWrData[0];
          CFG_MODE: begin
            avgSel    <= regWrData[7:5];
            cycleMode <= regWrData[0];
          end
          CFG_IDLE: idleLen <= regWrData;
          CFG_MASK: maskR   <= regWrData[NUM_CH-1:0];
          default: ;
        endcase
      end
      if (regWrEn && (wrIdx < IDX_W'(NUM_CH))) begin
        if (wrBank == BANK_HIGH) hiLim[wrIdx] <= regWrData;
        if (wrBank == BANK_LOW)  loLim[wrIdx] <= regWrData;
      end
    end
  end

  // accumulator and readings carry no reset
  always_ff @(posedge clk) begin
    if (strobe.take) accR <= sumNext;
    if (strobe.commit) readingR[strobe.chan] <= avgVal;
  end

  always_comb begin
    regRdData = '0;
    if (rdBank == BANK_CFG) begin
      case (rdIdx)
        CFG_CTRL: regRdData = {7'b0, runEn};
        CFG_MODE: regRdData = {avgSel, 4'b0, cycleMode};
        CFG_IDLE: regRdData = idleLen;
        CFG_STAT: regRdData = DATA_W'(statR);
        CFG_MASK: regRdData = DATA_W'(maskR);
        default:  regRdData = '0;
      endcase
    end else if (rdIdx < IDX_W'(NUM_CH)) begin
      case (rdBank)
        BANK_READ: regRdData = readingR[rdIdx];
        BANK_HIGH: regRdData = hiLim[rdIdx];
        default:   regRdData = loLim[rdIdx];
      endcase
    end
  end

  assign irq = |(statR & ~maskR);
endmodule

// File: rtl/hwmon_seq.sv
module hwmon_seq
  import hwmon_pkg::*;
#(
  parameter int TEMP_CLKS = 96,
  parameter int VOLT_CLKS = 68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic [DATA_W-1:0] sampleData,
  output logic              irq
);
  logic              runEn;
  logic              cycleMode;
  logic [2:0]        avgSel;
  logic [IDLE_W-1:0] idleLen;
  strobe_t           strobe;

  hwmon_ctrl #(.TEMP_CLKS(TEMP_CLKS), .VOLT_CLKS(VOLT_CLKS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convTick  (convTick),
    .runEn     (runEn),
    .cycleMode (cycleMode),
    .avgSel    (avgSel),
    .idleLen   (idleLen),
    .convStart (convStart),
    .convChan  (convChan),
    .strobe    (strobe)
  );

  hwmon_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .regRdAddr  (regRdAddr),
    .regRdData  (regRdData),
    .sampleData (sampleData),
    .strobe     (strobe),
    .runEn      (runEn),
    .cycleMode  (cycleMode),
    .avgSel     (avgSel),
    .idleLen    (idleLen),
    .irq        (irq)
  );
endmodule

// File: rtl/hwmon_seq_chk.sv
module hwmon_seq_chk
  import hwmon_pkg::*;
#(
  parameter int VOLT_CLKS = 68
) (
  input logic  clk,
  input logic  rstN,
  input logic  convStart,
  input chan_t convChan,
  input logic  irq,
  input logic  regWrEn,
  input logic  softWr,
  input logic  runEn
);
  localparam int GAP_MIN = VOLT_CLKS + 1;
  localparam int GAP_W   = $clog2(GAP_MIN + 1) + 1;

  logic [GAP_W-1:0] gap;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (convStart) begin
      gap   <= GAP_W'(1);
      armed <= 1'b1;
    end else if (gap < GAP_W'(GAP_MIN)) begin
      gap <= gap + GAP_W'(1);
    end
  end

  a_r2_start_gate: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(runEn));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && armed) |-> (gap >= GAP_W'(GAP_MIN)));

  a_r3_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (convChan < CH_W'(NUM_CH)));

  a_r9_irq_fall_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWrEn));

  a_r11_soft_stop: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (!convStart && !irq));
endmodule

bind hwmon_seq hwmon_seq_chk #(.VOLT_CLKS(VOLT_CLKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .convChan  (convChan),
  .irq       (irq),
  .regWrEn   (regWrEn),
  .softWr    (regWrEn && (regWrAddr == 5'd0) && regWrData[7]),
  .runEn     (runEn)
);

// File: tb/hwmon_seq_bench.sv
module hwmon_seq_bench;
  import hwmon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TEMP_LEN   = 96;
  localparam int VOLT_LEN   = 68;
  localparam logic [4:0] AD_CTRL = 5'h00, AD_MODE = 5'h01, AD_IDLE = 5'h02,
                         AD_STAT = 5'h03, AD_MASK = 5'h04, AD_READ = 5'h08,
                         AD_HIGH = 5'h10, AD_LOW = 5'h18;

  logic       clk = 1'b0, rstN = 1'b0, convTick = 1'b1, regWrEn = 1'b0;
  logic [4:0] regWrAddr = '0, regRdAddr = '0;
  logic [7:0] regWrData = '0, sampleData = '0;
  logic [7:0] regRdData;
  logic       convStart, irq;
  logic [2:0] convChan;

  hwmon_seq u_hwmon_seq (
    .clk(clk), .rstN(rstN), .convTick(convTick),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .convStart(convStart), .convChan(convChan),
    .sampleData(sampleData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, failed = 0, cyc = 0, startCount = 0;
  bit haveLast = 0, lastFinal = 0, pendValid = 0, monOn = 0, constPat = 0, tbCycle = 0;
  int lastCh = 0, lastCyc = 0, sum = 0, cnt = 0, sampleIdx = 0;
  int tbIdle = 4, tbN = 1, tbShift = 0;
  logic [15:0] pend;
  logic [15:0] monItem;
  logic [15:0] sbq[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int lenOf(input int ch);
    return (ch < TEMP_CH) ? TEMP_LEN : VOLT_LEN;
  endfunction

  // driver side of the scoreboard: converter model feeding samples and
  // pushing the expected reading once its last sample has been taken
  task automatic driveSample(input int ch);
    int v, expGap, expCh;
    startCount++;
    if (haveLast) begin
      expGap = lenOf(lastCh) + 1;
      if (lastFinal && lastCh == NUM_CH-1 && tbCycle) expGap += tbIdle + 1;
      check(cyc - lastCyc == expGap,
            (lastFinal && lastCh == NUM_CH-1) ? (tbCycle ? "R7" : "R6") : "R3",
            cyc - lastCyc, expGap);
      expCh = lastFinal ? (lastCh + 1) % NUM_CH : lastCh;
      check(ch == expCh, "R4", ch, expCh);
    end else begin
      check(ch == 0, "R3", ch, 0);
    end
    if (pendValid) begin
      sbq.push_back(pend);
      pendValid = 0;
    end
    v = constPat ? ch*40 + 20 : (ch*53 + sampleIdx*29 + 7) % 256;
    sampleIdx++;
    sampleData = v[7:0];
    sum += v;
    cnt++;
    lastFinal = (cnt == tbN);
    if (lastFinal) begin
      pend = {ch[7:0], 8'(sum >> tbShift)};
      pendValid = 1;
      sum = 0;
      cnt = 0;
    end
    lastCh = ch;
    lastCyc = cyc;
    haveLast = 1;
  endtask

  always @(negedge clk) if (rstN && convStart) driveSample(int'(convChan));

  // monitor side: pop expected readings and compare at the read port (R5)
  always @(posedge clk) begin
    #1;
    if (monOn && sbq.size() > 0) begin
      monItem = sbq.pop_front();
      regRdAddr = 5'(8 + monItem[15:8]);
      #1;
      check(regRdData == monItem[7:0], "R5", regRdData, monItem[7:0]);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectRd(input logic [4:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    regRdAddr = a;
    #1;
    check(regRdData == e, req, regRdData, e);
  endtask

  task automatic runPhase(input logic [7:0] mode, input int idle, input int cycles);
    int s;
    wr(AD_IDLE, 8'(idle));
    wr(AD_MODE, mode);
    tbCycle = mode[0];
    tbIdle = idle;
    tbShift = mode[7] ? 5 : mode[6] ? 4 : mode[5] ? 3 : 0;
    tbN = 1 << tbShift;
    haveLast = 0; pendValid = 0; sum = 0; cnt = 0;
    monOn = 1;
    wr(AD_CTRL, 8'h01);
    repeat (cycles) @(posedge clk);
    wr(AD_CTRL, 8'h00);
    repeat (4) @(posedge clk);
    monOn = 0;
    sbq.delete();
    s = startCount;
    repeat (300) @(posedge clk);
    check(startCount == s, "R2", startCount - s, 0);   // R2: stop halts
  endtask

  initial begin
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: defaults
    expectRd(AD_CTRL, 8'h00, "R1");
    expectRd(AD_MODE, 8'h00, "R1");
    expectRd(AD_IDLE, 8'd4,  "R1");
    expectRd(AD_STAT, 8'h00, "R1");
    expectRd(AD_MASK, 8'h00, "R1");
    expectRd(AD_HIGH + 5'd0, 8'hFF, "R1");
    expectRd(AD_HIGH + 5'd4, 8'hFF, "R1");
    expectRd(AD_LOW + 5'd1, 8'h00, "R1");
    check(irq == 1'b0, "R1", irq, 0);

    // R2: nothing starts before the run bit
    repeat (200) @(posedge clk);
    check(startCount == 0, "R2", startCount, 0);

    runPhase(8'h00, 4, 1300);     // R6 free-running, single sample
    runPhase(8'h21, 10, 7000);    // R7 paced, 8 samples
    runPhase(8'h60, 4, 7000);     // R4 bit 6 beats bit 5: 16 samples
    runPhase(8'hA0, 4, 13500);    // R4 bit 7 wins: 32 samples

    // R8: strict limit compare with constant samples 20,60,100,140,180
    constPat = 1;
    wr(AD_HIGH + 5'd0, 8'd19);
    wr(AD_HIGH + 5'd1, 8'd60);
    wr(AD_LOW + 5'd2, 8'd101);
    wr(AD_LOW + 5'd3, 8'd140);
    runPhase(8'h00, 4, 600);
    expectRd(AD_STAT, 8'h05, "R8");
    check(irq == 1'b1, "R10", irq, 1);
    wr(AD_MASK, 8'h05);
    check(irq == 1'b0, "R10", irq, 0);
    wr(AD_MASK, 8'h04);
    check(irq == 1'b1, "R10", irq, 1);
    wr(AD_MASK, 8'h00);
    wr(AD_STAT, 8'h01);
    expectRd(AD_STAT, 8'h04, "R9");
    wr(AD_STAT, 8'h00);
    expectRd(AD_STAT, 8'h04, "R9");
    check(irq == 1'b1, "R9", irq, 1);

    // R11: soft reset while stopped keeps readings
    wr(AD_MASK, 8'h02);
    wr(AD_IDLE, 8'd9);
    wr(AD_CTRL, 8'h80);
    expectRd(AD_CTRL, 8'h00, "R11");
    expectRd(AD_STAT, 8'h00, "R11");
    expectRd(AD_MASK, 8'h00, "R11");
    expectRd(AD_IDLE, 8'd4, "R11");
    expectRd(AD_HIGH + 5'd0, 8'hFF, "R11");
    expectRd(AD_LOW + 5'd2, 8'h00, "R11");
    check(irq == 1'b0, "R11", irq, 0);
    for (int c = 0; c < NUM_CH; c++)
      expectRd(AD_READ + 5'(c), 8'(c*40 + 20), "R11");

    // R11: soft reset while running, bit 0 written with it
    constPat = 0;
    wr(AD_MODE, 8'h01);
    haveLast = 0; tbCycle = 1; tbIdle = 4; tbN = 1; tbShift = 0;
    wr(AD_CTRL, 8'h01);
    repeat (300) @(posedge clk);
    wr(AD_CTRL, 8'h81);
    expectRd(AD_CTRL, 8'h00, "R11");
    expectRd(AD_MODE, 8'h00, "R11");
    s = startCount;
    repeat (300) @(posedge clk);
    check(startCount == s, "R11", startCount - s, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule